// File: doc/BRIEF.md
# Redundant Oscillator Failover Controller

This block sits on a clock chip that receives two redundant oscillator feeds. It decides which feed drives the chip, and it moves to the other feed when the active one fails. It works only on sampled digital fault flags. For each feed these are a wire-test error on each leg of the differential pair and a missing-edge indication. It also watches a system-wide select line that every chip sees in the same cycle. The analog receivers, the edge-merging flip-flop and the delay lines are outside this block. It only produces the select, the lock and the status.

Each feed is given a role: off, main, standby or solo. While unlocked, the active feed follows the configured main or solo feed. A switchover has two triggers: a filtered fault on the active feed, or any change of the select line. Either trigger succeeds only when the other feed is configured as standby and is free of faults. After a switchover a lock holds the new choice, so an intermittent fault cannot make the chip bounce back. Software clears the lock with a rearm command, and the command takes effect only while neither feed shows a fault. A status register keeps sticky fault causes, which are cleared by writing 1, next to live bits. Each feed also gets a two-bit status output.

Top module: `osc_failover`

## Requirements
- R1: Role encoding per feed is 00 off, 01 main, 10 standby, 11 solo. While unlocked, the active feed (`act_src`, 0 = feed 0) is feed 0 when feed 0 is main or solo, else feed 1 when feed 1 is main or solo, else feed 0. Reset gives `act_src`=0 and `sw_lock`=0.
- R2: A raw fault on a feed is the OR of its positive-leg error, its negative-leg error and its missing-edge flag. A broken leg alone therefore counts as a fault.
- R3: A raw fault becomes a filtered fault only after FILT_LEN consecutive sampled cycles (default 3). A shorter burst never causes a switchover. The filtered fault drops one cycle after the raw fault goes away.
- R4: A switchover happens only when the non-active feed has role standby and has no filtered fault.
- R5: After a switchover `sw_lock` is 1 and `act_src` keeps its value until an accepted rearm. This holds even if the new feed then fails.
- R6: Any change of `sel_cmd` while unlocked causes a switchover on the next clock edge, provided R4 allows it.
- R7: A filtered fault on the active feed switches the chip on the next edge, without any change of `sel_cmd`.
- R8: A write with `wr_data[5]`=1 is a rearm. It clears the lock, and the active feed returns to the one chosen by R1, only when neither feed has a filtered fault. Otherwise the lock stays.
- R9: `stat_reg[4:0]` are sticky bits. Bit 0 is a leg fault on feed 0 and bit 1 a leg fault on feed 1, each recorded while that feed's filter is active. Bit 2 is a missing edge on feed 0 and bit 3 a missing edge on feed 1, under the same condition. Bit 4 records that a switchover happened. A write clears each bit whose `wr_data` bit is 1. A set in the same cycle wins over the clear.
- R10: `osc_stat0`/`osc_stat1` bit 0 is 1 when that feed's role is not off and it has no filtered fault. Bit 1 equals the lock.
- R11: `stat_reg[5]` is `act_src`, `stat_reg[6]` is the lock, and `stat_reg[7]` is 1 when the non-active feed has role standby and no filtered fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| role0 | input | 2 | Role of feed 0 |
| role1 | input | 2 | Role of feed 1 |
| leg_p_err | input | 2 | Positive-leg wire-test error, bit i = feed i |
| leg_n_err | input | 2 | Negative-leg wire-test error, bit i = feed i |
| miss_edge | input | 2 | Missing-edge fault, bit i = feed i |
| sel_cmd | input | 1 | System select line; a change commands a switchover |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 6 | [4:0] clear-by-one mask, [5] rearm |
| act_src | output | 1 | Active feed |
| sw_lock | output | 1 | Switchover lock |
| stat_reg | output | 8 | Status register |
| osc_stat0 | output | 2 | Status toward feed 0 |
| osc_stat1 | output | 2 | Status toward feed 1 |

## Verification
Two events can land on the same clock edge. A filtered leg fault can set a sticky bit in the cycle where software writes 1 to clear that same bit. The bench provokes this by holding a leg error on the standby feed until its filter just fires, then issuing the clear on exactly that edge. The design passes if the bit reads back as set. The bench also lets a rearm land while a feed still carries a filtered fault, and expects the lock to remain.

// File: rtl/osw_pkg.sv
package osw_pkg;
  typedef enum logic [1:0] {
    ROLE_OFF  = 2'b00,
    ROLE_MAIN = 2'b01,
    ROLE_STBY = 2'b10,
    ROLE_SOLO = 2'b11
  } role_e;

  localparam int NSRC   = 2;
  localparam int STK_W  = 5;
  localparam int CMD_W  = 6;
  localparam int STAT_W = 8;

  localparam int STK_LEG0  = 0;
  localparam int STK_LEG1  = 1;
  localparam int STK_MISS0 = 2;
  localparam int STK_MISS1 = 3;
  localparam int STK_SW    = 4;
  localparam int CMD_REARM = 5;
endpackage

// File: rtl/osw_glitch_filter.sv
module osw_glitch_filter #(
  parameter int LEN = 3
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic raw_i,
  output logic flt_o
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LEN_C = CW'(LEN);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = raw_i ? (cnt_q != LEN_C) : (cnt_q != '0);
    cnt_d  = raw_i ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign flt_o = (cnt_q == LEN_C);

  // R3: a filtered fault only appears after the raw flag was present
  p_flt_needs_raw_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(flt_o) |-> $past(raw_i));
  // R3: the filtered fault is gone one cycle after the raw flag drops
  p_flt_drop_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    !raw_i |=> !flt_o);
endmodule

// File: rtl/osw_select_ctrl.sv
module osw_select_ctrl
  import osw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [NSRC-1:0][1:0] role_i,
  input  logic [NSRC-1:0]      flt_i,
  input  logic                 sel_i,
  input  logic                 rearm_req_i,
  output logic                 act_o,
  output logic                 lock_o,
  output logic                 sw_evt_o,
  output logic                 alt_ok_o
);
  logic act_q, act_d, lock_q, lock_d;
  logic sel_q, sel_vld_q;
  logic tgl, home, alt, alt_ok, act_flt, rearm_ok, sw_evt;
  logic [NSRC-1:0] is_main;

  for (genvar g = 0; g < NSRC; g++) begin : g_main
    assign is_main[g] = (role_i[g] == ROLE_MAIN) || (role_i[g] == ROLE_SOLO);
  end

  always_comb begin
    home     = !is_main[0] && is_main[1];
    alt      = !act_q;
    alt_ok   = (role_i[alt] == ROLE_STBY) && !flt_i[alt];
    act_flt  = flt_i[act_q];
    tgl      = sel_vld_q && (sel_i != sel_q);
    rearm_ok = rearm_req_i && (flt_i == '0);
    sw_evt   = !lock_q && alt_ok && (act_flt || tgl);
  end

  always_comb begin
    act_d  = act_q;
    lock_d = lock_q;
    if (lock_q) begin
      if (rearm_ok) begin
        lock_d = 1'b0;
        act_d  = home;
      end
    end else if (sw_evt) begin
      lock_d = 1'b1;
      act_d  = alt;
    end else begin
      act_d = home;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      lock_q    <= 1'b0;
      sel_q     <= 1'b0;
      sel_vld_q <= 1'b0;
    end else begin
      act_q     <= act_d;
      lock_q    <= lock_d;
      sel_q     <= sel_i;
      sel_vld_q <= 1'b1;
    end
  end

  assign act_o    = act_q;
  assign lock_o   = lock_q;
  assign sw_evt_o = sw_evt;
  assign alt_ok_o = alt_ok;

  // R4: lock only rises when the standby feed was usable
  p_switch_needs_alt_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(alt_ok));
  // R5: a held lock freezes the selection
  p_lock_holds_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (lock_q && !rearm_ok) |=> (lock_q && $stable(act_q)));
  // R6: a select change while unlocked with a usable standby switches
  p_toggle_switch_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!lock_q && tgl && alt_ok) |=> lock_q);
  // R8: lock only falls when neither feed is faulty
  p_rearm_guard_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(lock_q) |-> $past(flt_i == '0));
endmodule

// File: rtl/osw_status_reg.sv
module osw_status_reg
  import osw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [STK_W-1:0]  clr_i,
  input  logic [NSRC-1:0]   flt_i,
  input  logic [NSRC-1:0]   leg_i,
  input  logic [NSRC-1:0]   miss_i,
  input  logic              sw_evt_i,
  input  logic              act_i,
  input  logic              lock_i,
  input  logic              alt_ok_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STK_W-1:0] stk_q, stk_d, set_v, clr_v, keep_v;
  logic             stk_en;

  always_comb begin
    set_v            = '0;
    set_v[STK_LEG0]  = flt_i[0] && leg_i[0];
    set_v[STK_LEG1]  = flt_i[1] && leg_i[1];
    set_v[STK_MISS0] = flt_i[0] && miss_i[0];
    set_v[STK_MISS1] = flt_i[1] && miss_i[1];
    set_v[STK_SW]    = sw_evt_i;
    clr_v            = we_i ? clr_i : '0;
    keep_v           = stk_q & ~clr_v;
    stk_d            = set_v | keep_v;
    stk_en           = we_i || (set_v != '0);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     stk_q <= '0;
    else if (stk_en) stk_q <= stk_d;
  end

  assign stat_o = {alt_ok_i, lock_i, act_i, stk_q};

  // R9: a sticky bit not written with 1 is never lost
  p_sticky_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((stk_q & $past(keep_v)) == $past(keep_v)));
  // R9: a set request always lands, even against a clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((stk_q & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/osc_failover.sv
module osc_failover
  import osw_pkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  role0,
  input  logic [1:0]  role1,
  input  logic [1:0]  leg_p_err,
  input  logic [1:0]  leg_n_err,
  input  logic [1:0]  miss_edge,
  input  logic        sel_cmd,
  input  logic        wr_en,
  input  logic [5:0]  wr_data,
  output logic        act_src,
  output logic        sw_lock,
  output logic [7:0]  stat_reg,
  output logic [1:0]  osc_stat0,
  output logic [1:0]  osc_stat1
);
  logic [1:0]            rst_sync_q;
  logic                  rst_ni;
  logic [NSRC-1:0][1:0]  role_v;
  logic [NSRC-1:0]       leg_v, raw_v, flt_v, run_v;
  logic                  sw_evt, alt_ok, act_w, lock_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  assign role_v = {role1, role0};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign leg_v[g] = leg_p_err[g] || leg_n_err[g];
    assign raw_v[g] = leg_v[g] || miss_edge[g];
    assign run_v[g] = (role_v[g] != ROLE_OFF) && !flt_v[g];

    osw_glitch_filter #(.LEN(FILT_LEN)) u_filt (
      .clk   (clk),
      .rst_ni(rst_ni),
      .raw_i (raw_v[g]),
      .flt_o (flt_v[g])
    );
  end

  osw_select_ctrl u_ctrl (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .role_i     (role_v),
    .flt_i      (flt_v),
    .sel_i      (sel_cmd),
    .rearm_req_i(wr_en && wr_data[CMD_REARM]),
    .act_o      (act_w),
    .lock_o     (lock_w),
    .sw_evt_o   (sw_evt),
    .alt_ok_o   (alt_ok)
  );

  osw_status_reg u_stat (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .clr_i   (wr_data[STK_W-1:0]),
    .flt_i   (flt_v),
    .leg_i   (leg_v),
    .miss_i  (miss_edge),
    .sw_evt_i(sw_evt),
    .act_i   (act_w),
    .lock_i  (lock_w),
    .alt_ok_i(alt_ok),
    .stat_o  (stat_reg)
  );

  assign act_src   = act_w;
  assign sw_lock   = lock_w;
  assign osc_stat0 = {lock_w, run_v[0]};
  assign osc_stat1 = {lock_w, run_v[1]};

  // R7: a filtered fault on the active feed with usable standby switches next edge
  p_local_fault_r7: assert property (@(posedge rst_ni ? clk : 1'b0) disable iff (!rst_ni)
    (!lock_w && flt_v[act_w] && alt_ok) |=> (lock_w && act_src != $past(act_src)));
endmodule

// File: tb/osc_failover_test.sv
module osc_failover_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] role0, role1, leg_p_err, leg_n_err, miss_edge;
  logic       sel_cmd, wr_en;
  logic [5:0] wr_data;
  logic       act_src, sw_lock;
  logic [7:0] stat_reg;
  logic [1:0] osc_stat0, osc_stat1;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  osc_failover uut (
    .clk(clk), .rst_n(rst_n), .role0(role0), .role1(role1),
    .leg_p_err(leg_p_err), .leg_n_err(leg_n_err), .miss_edge(miss_edge),
    .sel_cmd(sel_cmd), .wr_en(wr_en), .wr_data(wr_data),
    .act_src(act_src), .sw_lock(sw_lock), .stat_reg(stat_reg),
    .osc_stat0(osc_stat0), .osc_stat1(osc_stat1)
  );

  typedef struct packed {
    logic [1:0] r0, r1, ep, en, ms;
    logic       sel, we;
    logic [5:0] wd;
    logic [3:0] cyc;
    logic       eact, elock;
    logic [7:0] estat;
    logic [1:0] eos0, eos1;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{2'd1,2'd2,2'd0,2'd0,2'd0,1'b0,1'b0,6'h00,4'd2,1'b0,1'b0,8'h80,2'd1,2'd1}, // R1 home is main
    '{2'd1,2'd2,2'd1,2'd0,2'd0,1'b0,1'b0,6'h00,4'd2,1'b0,1'b0,8'h80,2'd1,2'd1}, // R3 short burst
    '{2'd1,2'd2,2'd0,2'd0,2'd0,1'b0,1'b0,6'h00,4'd3,1'b0,1'b0,8'h80,2'd1,2'd1}, // R3 burst rejected
    '{2'd1,2'd2,2'd0,2'd1,2'd0,1'b0,1'b0,6'h00,4'd4,1'b1,1'b1,8'h71,2'd2,2'd3}, // R2 R7 n-leg fault
    '{2'd1,2'd2,2'd0,2'd0,2'd0,1'b0,1'b0,6'h00,4'd4,1'b1,1'b1,8'h71,2'd3,2'd3}, // R5 fault gone
    '{2'd1,2'd2,2'd0,2'd0,2'd2,1'b0,1'b0,6'h00,4'd5,1'b1,1'b1,8'h79,2'd3,2'd2}, // R5 no return
    '{2'd1,2'd2,2'd0,2'd0,2'd2,1'b0,1'b1,6'h20,4'd2,1'b1,1'b1,8'h79,2'd3,2'd2}, // R8 rearm refused
    '{2'd1,2'd2,2'd0,2'd0,2'd0,1'b0,1'b0,6'h00,4'd2,1'b1,1'b1,8'h79,2'd3,2'd3}, // R9 sticky held
    '{2'd1,2'd2,2'd0,2'd0,2'd0,1'b0,1'b1,6'h3F,4'd2,1'b0,1'b0,8'h80,2'd1,2'd1}, // R8 R9 rearm+clear
    '{2'd1,2'd2,2'd0,2'd0,2'd0,1'b1,1'b0,6'h00,4'd1,1'b1,1'b1,8'h70,2'd3,2'd3}, // R6 select change
    '{2'd1,2'd2,2'd0,2'd0,2'd0,1'b1,1'b1,6'h30,4'd2,1'b0,1'b0,8'h80,2'd1,2'd1}, // R8 rearm
    '{2'd1,2'd0,2'd0,2'd0,2'd1,1'b1,1'b0,6'h00,4'd5,1'b0,1'b0,8'h04,2'd0,2'd0}, // R4 no standby
    '{2'd1,2'd2,2'd0,2'd0,2'd1,1'b1,1'b0,6'h00,4'd2,1'b1,1'b1,8'h74,2'd2,2'd3}, // R4 R7 standby back
    '{2'd1,2'd2,2'd0,2'd0,2'd0,1'b0,1'b0,6'h00,4'd2,1'b1,1'b1,8'h74,2'd3,2'd3}, // R5 R6 select while locked
    '{2'd1,2'd2,2'd0,2'd0,2'd0,1'b0,1'b1,6'h34,4'd2,1'b0,1'b0,8'h80,2'd1,2'd1}, // R8 rearm
    '{2'd1,2'd2,2'd2,2'd0,2'd0,1'b0,1'b0,6'h00,4'd3,1'b0,1'b0,8'h00,2'd1,2'd0}, // R11 standby faulty
    '{2'd1,2'd2,2'd2,2'd0,2'd0,1'b0,1'b1,6'h02,4'd1,1'b0,1'b0,8'h02,2'd1,2'd0}, // R9 set beats clear
    '{2'd1,2'd2,2'd0,2'd0,2'd0,1'b0,1'b1,6'h02,4'd2,1'b0,1'b0,8'h80,2'd1,2'd1}, // R9 clear
    '{2'd0,2'd3,2'd0,2'd0,2'd0,1'b0,1'b0,6'h00,4'd2,1'b1,1'b0,8'h20,2'd0,2'd1}, // R1 solo on feed 1
    '{2'd0,2'd3,2'd0,2'd0,2'd2,1'b0,1'b0,6'h00,4'd5,1'b1,1'b0,8'h28,2'd0,2'd0}  // R4 solo cannot switch
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    role0 = 2'd0; role1 = 2'd0;
    leg_p_err = '0; leg_n_err = '0; miss_edge = '0;
    sel_cmd = 1'b0; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset act_src", {7'd0, act_src}, 8'd0);
    chk("R5 reset lock", {7'd0, sw_lock}, 8'd0);
    chk("R9 reset stat", stat_reg, 8'h00);
    chk("R10 reset osc_stat", {4'd0, osc_stat1, osc_stat0}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      role0 = TBL[i].r0; role1 = TBL[i].r1;
      leg_p_err = TBL[i].ep; leg_n_err = TBL[i].en; miss_edge = TBL[i].ms;
      sel_cmd = TBL[i].sel; wr_en = TBL[i].we; wr_data = TBL[i].wd;
      for (int c = 0; c < int'(TBL[i].cyc); c++) begin
        @(negedge clk);
        wr_en = 1'b0;
      end
      chk($sformatf("R1 step%0d act_src", i), {7'd0, act_src}, {7'd0, TBL[i].eact});
      chk($sformatf("R5 step%0d lock", i), {7'd0, sw_lock}, {7'd0, TBL[i].elock});
      chk($sformatf("R9 R11 step%0d stat", i), stat_reg, TBL[i].estat);
      chk($sformatf("R10 step%0d osc_stat0", i), {6'd0, osc_stat0}, {6'd0, TBL[i].eos0});
      chk($sformatf("R10 step%0d osc_stat1", i), {6'd0, osc_stat1}, {6'd0, TBL[i].eos1});
    end

    // R1: reset taken mid-run clears the sticky bits and the selection
    miss_edge = '0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 midrun reset act_src", {7'd0, act_src}, 8'd0);
    chk("R9 midrun reset stat", stat_reg, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset solo feed 1", {7'd0, act_src}, 8'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule